// File: doc/BRIEF.md
# Ticket Lock Manager

This block arbitrates one shared lock among a fixed number of agents. It keeps two wrapping counters: a dispenser value, which is the next ticket to issue, and a service value, which is the ticket that may own the lock now. An agent asks for a ticket through a valid/ready handshake. The handshake is the single atomic fetch-and-increment of the acquire. It happens when the agent arrives, not when the lock becomes free. The agent then keeps its ticket in a per-agent register. It owns the lock while its ticket equals the service value.

Giving up the lock advances the service value by one. This hands the lock to the holder of the next ticket. Grants therefore follow the order in which tickets were issued. When several agents ask in the same cycle, a fixed-priority arbiter serves one request per cycle, lowest index first. A release pulse from an agent that does not own the lock changes nothing and raises an error flag for one cycle.

Back-pressure rules for the acquire handshake:
- `acq_ready[i]` is computed combinationally from `acq_valid`.
- A ticket is taken on a clock edge where `acq_valid[i]` and `acq_ready[i]` are both high.
- An agent keeps `acq_valid[i]` high until that edge.
- An agent that already holds a ticket sees `acq_ready[i]` low until it has released.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset, every `grant` bit and `rel_err` are low, and the first ticket issued is 0.
- R2: `acq_ready[i]` is high only if all of the following hold: `acq_valid[i]` is high, agent i holds no ticket, and no lower-index agent is asking without a ticket. At most one `acq_ready` bit is high per cycle.
- R3: On a handshake, the agent receives the current dispenser value on its slice `ticket[i*TICKET_W +: TICKET_W]`. The dispenser then advances by one, modulo 2^TICKET_W.
- R4: `grant[i]` is registered. It is high exactly when agent i holds a ticket equal to the service value. At most one `grant` bit is high at a time. When a handshake issues a ticket equal to the service value, the grant rises at that same edge.
- R5: A grant stays high until its owner pulses `rel_valid[i]`. At that edge the owner's grant falls, the service value advances by one, and the holder of the next ticket (if any) is granted at the same edge.
- R6: A `rel_valid[i]` pulse while `grant[i]` is low leaves the counters and all grants unchanged. It sets `rel_err` high for the one cycle after that edge.
- R7: Grants are given in the order the tickets were issued. Same-cycle requesters are ordered lowest index first.
- R8: Both counters wrap modulo 2^TICKET_W. Issuing and granting keep working correctly across many wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | NUM_AGENTS | Per-agent ticket request |
| acq_ready | output | NUM_AGENTS | Per-agent ticket accept (one-hot or zero) |
| rel_valid | input | NUM_AGENTS | Per-agent release pulse |
| grant | output | NUM_AGENTS | Per-agent lock ownership, registered |
| ticket | output | NUM_AGENTS*TICKET_W | Per-agent held ticket value |
| rel_err | output | 1 | Pulse after a release from a non-owner |

## Verification
The assertions check the following on every cycle:
- accepts are one-hot and only ever follow a request;
- ownership is mutually exclusive;
- an owner keeps the lock until it releases, and loses it at the edge where it releases;
- the error flag is set by exactly the releases that come from non-owners.

Some behaviours involve the sequence of tickets over time, which the per-cycle properties cannot see, so only the bench scenarios show them:
- tickets come out in order;
- lower-index agents win when they ask in the same cycle;
- grants follow ticket order across counter wraps;
- a non-owner's release leaves ownership where it was.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  localparam int unsigned DEF_AGENTS   = 4;
  localparam int unsigned DEF_TICKET_W = 3;
endpackage

// File: rtl/tlk_arbiter.sv
module tlk_arbiter #(
  parameter int unsigned NA = 4
) (
  input  logic [NA-1:0] req,
  output logic [NA-1:0] win,
  output logic          any
);
  // lowest set bit wins
  assign win = req & (~req + NA'(1));
  assign any = |req;
endmodule

// File: rtl/tlk_counters.sv
module tlk_counters #(
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          advance,
  output logic [TW-1:0] dispense,
  output logic [TW-1:0] serving,
  output logic [TW-1:0] serving_nxt
);
  assign serving_nxt = serving + TW'(advance);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dispense <= '0;
      serving  <= '0;
    end else begin
      if (issue) dispense <= dispense + TW'(1);
      serving <= serving_nxt;
    end
  end
endmodule

// File: rtl/tlk_slot.sv
module tlk_slot #(
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [TW-1:0] tkt_in,
  input  logic          rel_ok,
  input  logic [TW-1:0] serving_nxt,
  output logic          holding,
  output logic [TW-1:0] tkt,
  output logic          grant
);
  logic          holding_nxt;
  logic [TW-1:0] tkt_nxt;

  always_comb begin
    holding_nxt = holding;
    tkt_nxt     = tkt;
    if (take) begin
      holding_nxt = 1'b1;
      tkt_nxt     = tkt_in;
    end else if (rel_ok) begin
      holding_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holding <= 1'b0;
      tkt     <= '0;
      grant   <= 1'b0;
    end else begin
      holding <= holding_nxt;
      tkt     <= tkt_nxt;
      grant   <= holding_nxt && (tkt_nxt == serving_nxt);
    end
  end
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int unsigned NUM_AGENTS = tlk_pkg::DEF_AGENTS,
  parameter int unsigned TICKET_W   = tlk_pkg::DEF_TICKET_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_AGENTS-1:0]          acq_valid,
  output logic [NUM_AGENTS-1:0]          acq_ready,
  input  logic [NUM_AGENTS-1:0]          rel_valid,
  output logic [NUM_AGENTS-1:0]          grant,
  output logic [NUM_AGENTS*TICKET_W-1:0] ticket,
  output logic                           rel_err
);
  localparam int unsigned NA = NUM_AGENTS;
  localparam int unsigned TW = TICKET_W;

  logic [NA-1:0] holding;
  logic [NA-1:0] eligible;
  logic [NA-1:0] rel_ok;
  logic          issue;
  logic [TW-1:0] dispense, serving, serving_nxt;

  assign eligible = acq_valid & ~holding;
  assign rel_ok   = rel_valid & grant;

  tlk_arbiter #(.NA(NA)) u_arb (
    .req (eligible),
    .win (acq_ready),
    .any (issue)
  );

  tlk_counters #(.TW(TW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .advance     (|rel_ok),
    .dispense    (dispense),
    .serving     (serving),
    .serving_nxt (serving_nxt)
  );

  for (genvar g = 0; g < NA; g++) begin : g_slot
    tlk_slot #(.TW(TW)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (acq_ready[g]),
      .tkt_in      (dispense),
      .rel_ok      (rel_ok[g]),
      .serving_nxt (serving_nxt),
      .holding     (holding[g]),
      .tkt         (ticket[g*TW +: TW]),
      .grant       (grant[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rel_err <= 1'b0;
    else        rel_err <= |(rel_valid & ~grant);
  end
endmodule

// File: rtl/tlk_checker.sv
module tlk_checker #(
  parameter int unsigned NA = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NA-1:0] acq_valid,
  input logic [NA-1:0] acq_ready,
  input logic [NA-1:0] rel_valid,
  input logic [NA-1:0] grant,
  input logic          rel_err
);
  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acq_ready)); // R2
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_ready & ~acq_valid) == '0); // R2
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    |(rel_valid & ~grant) |=> rel_err); // R6
  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(rel_valid & ~grant)) |=> !rel_err); // R6
  for (genvar g = 0; g < NA; g++) begin : g_own
    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] && !rel_valid[g] |=> grant[g]); // R5
    AST_DROP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] && rel_valid[g] |=> !grant[g]); // R5
  end
endmodule

bind ticket_lock_unit tlk_checker #(.NA(NUM_AGENTS)) u_tlk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acq_valid (acq_valid),
  .acq_ready (acq_ready),
  .rel_valid (rel_valid),
  .grant     (grant),
  .rel_err   (rel_err)
);

// File: tb/test_ticket_lock_unit.sv
module test_ticket_lock_unit;
  localparam int NA = 4;
  localparam int TW = 3;
  localparam int M  = 1 << TW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NA-1:0]   acq_valid = '0;
  logic [NA-1:0]   rel_valid = '0;
  logic [NA-1:0]   acq_ready;
  logic [NA-1:0]   grant;
  logic [NA*TW-1:0] ticket;
  logic            rel_err;

  ticket_lock_unit #(.NUM_AGENTS(NA), .TICKET_W(TW)) i_ticket_lock_unit (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_ready(acq_ready),
    .rel_valid(rel_valid), .grant(grant), .ticket(ticket), .rel_err(rel_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  int            disp_m = 0;
  int            serv_m = 0;
  int            tk_m [NA];
  bit            has_m [NA];
  logic [NA-1:0] want = '0;
  logic [NA-1:0] g_m = '0;
  logic          err_m = 1'b0;
  int            issued = 0;
  int            grant_seq = 0;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NA-1:0] exp_ready(input logic [NA-1:0] v);
    logic [NA-1:0] r = '0;
    for (int i = 0; i < NA; i++)
      if (v[i] && !has_m[i]) begin r[i] = 1'b1; break; end
    return r;
  endfunction

  task automatic step(input logic [NA-1:0] rel);
    logic [NA-1:0] rdy_m;
    logic [NA-1:0] g_old;
    @(negedge clk);
    chk("R4 grant", grant == g_m, int'(grant), int'(g_m));
    chk("R6 rel_err", rel_err == err_m, int'(rel_err), int'(err_m));
    for (int i = 0; i < NA; i++)
      if (has_m[i])
        chk("R3 ticket", int'(ticket[i*TW +: TW]) == tk_m[i],
            int'(ticket[i*TW +: TW]), tk_m[i]);
    acq_valid = want;
    rel_valid = rel;
    #1;
    rdy_m = exp_ready(want);
    chk("R2 acq_ready", acq_ready == rdy_m, int'(acq_ready), int'(rdy_m));
    for (int i = 0; i < NA; i++)
      if (rdy_m[i]) begin
        tk_m[i] = disp_m; has_m[i] = 1; want[i] = 1'b0;
        disp_m = (disp_m + 1) % M; issued++;
      end
    err_m = 1'b0;
    for (int i = 0; i < NA; i++)
      if (rel[i]) begin
        if (g_m[i]) begin serv_m = (serv_m + 1) % M; has_m[i] = 0; end
        else err_m = 1'b1;
      end
    g_old = g_m;
    for (int i = 0; i < NA; i++) g_m[i] = has_m[i] && (tk_m[i] == serv_m);
    for (int i = 0; i < NA; i++)
      if (g_m[i] && !g_old[i]) begin
        chk("R7 fifo order", tk_m[i] == grant_seq, tk_m[i], grant_seq);
        grant_seq = (grant_seq + 1) % M;
      end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NA; i++) begin tk_m[i] = 0; has_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 grant", grant == '0, int'(grant), 0);
    chk("R1 rel_err", rel_err == 1'b0, int'(rel_err), 0);

    // R7: all agents ask at once, lowest index gets lowest ticket
    want = '1;
    repeat (4) step('0);
    step('0);
    for (int i = 0; i < NA; i++)
      chk("R7 same-cycle order", tk_m[i] == i, int'(ticket[i*TW +: TW]), i);
    chk("R1 first ticket zero", int'(ticket[0 +: TW]) == 0, int'(ticket[0 +: TW]), 0);

    // R6: non-owner release is ignored and flagged
    step(4'b0100);
    step('0);
    chk("R6 owner kept", grant == 4'b0001, int'(grant), 1);

    // R5: owner releases, next ticket holder granted at same edge
    step(4'b0001);
    step('0);
    chk("R5 handover", grant == 4'b0010, int'(grant), 2);

    // constrained random traffic, crossing many counter wraps
    for (int n = 0; n < 3000; n++) begin
      logic [NA-1:0] rel = '0;
      for (int i = 0; i < NA; i++)
        if (!has_m[i] && !want[i] && ($urandom % 4 == 0)) want[i] = 1'b1;
      for (int i = 0; i < NA; i++)
        if (g_m[i] && ($urandom % 3 == 0)) rel[i] = 1'b1;
      if ($urandom % 16 == 0) begin
        int j = int'($urandom % NA);
        if (!g_m[j]) rel[j] = 1'b1;
      end
      step(rel);
    end
    want = '0;
    step('0);
    chk("R8 wraps exercised", issued > 4 * M, issued, 4 * M);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule